// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Flags

This block is a first-in first-out buffer for 9-bit words. It sits between two clock domains that have no fixed phase or frequency relation. Words are stored on rising edges of the write clock and delivered on rising edges of the read clock. The storage is an inferred register array whose depth is a power-of-two parameter.

Four status outputs report the fill level. Two are exact boundary flags, empty and full, and both are active low. Two are early-warning flags, almost-empty and almost-full, and both are active high. Each flag is produced only from registers clocked in its own domain. Fill levels cross between domains as Gray-coded pointers through two-flop synchronisers, so a flag can clear later than the true state but never earlier.

The warning thresholds come in as offset values from a separate offset register block. A level sampled on the second write enable while reset is held selects the mode. In one mode the second write enable is a write qualifier. In the other mode the second write enable is handed to offset loading and the first write enable alone qualifies writes.

Top module: `twoclk_fifo9`

## Requirements
- R1: In two-enable mode, a word is stored on a rising `wr_clk` edge only when `wr_en1_n` is 0, `wr_en2` is 1 and `full_n` is 1. When `wr_en2` is 0, the write is ignored.
- R2: A word is read on a rising `rd_clk` edge only when `rd_en1_n` and `rd_en2_n` are both 0 and `empty_n` is 1. Each such edge loads the next stored word into the registered `dout`. If only one of the two read enables is 0, nothing is read.
- R3: Writes attempted while `full_n` is 0 are ignored. Reads attempted while `empty_n` is 0 are ignored, and `dout` keeps the word from the last valid read.
- R4: Words come out in the order they were accepted, with none lost or duplicated, under unrelated clock periods. The buffer holds exactly DEPTH words.
- R5: `empty_n` and `aempty` change only at rising `rd_clk` edges. `full_n` and `afull` change only at rising `wr_clk` edges. Reset is the only exception.
- R6: With `ofs_prog` = 0, the default offset of 7 applies. Once both domains are quiet for three clocks each, with fill level n: `empty_n` = (n != 0), `full_n` = (n != DEPTH), `aempty` = (n <= 7) and `afull` = (n >= DEPTH - 7).
- R7: With `ofs_prog` = 1, the thresholds become `aempty` = (n <= `ae_ofs`) and `afull` = (n >= DEPTH - `af_ofs`). Both use the same settled fill level n as R6.
- R8: While `rst_n` is 0, the block is emptied. The outputs are `empty_n` = 0, `full_n` = 1, `aempty` = 1, `afull` = 0 and `dout` = 0. Reads and writes attempted during reset store or remove nothing.
- R9: The `wr_en2` level at the last `wr_clk` edge with `rst_n` = 0 selects the mode. A level of 1 selects two-enable mode. A level of 0 selects offset-loading mode, in which `wr_en1_n` = 0 alone qualifies a write and `wr_en2` is ignored for data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| rd_clk | input | 1 | Read-domain clock |
| rst_n | input | 1 | Reset for both domains, active low, asynchronous assert |
| wr_en1_n | input | 1 | First write enable, active low |
| wr_en2 | input | 1 | Second write enable (active high), or the mode strap during reset |
| din | input | DW | Write data |
| rd_en1_n | input | 1 | First read enable, active low |
| rd_en2_n | input | 1 | Second read enable, active low |
| ofs_prog | input | 1 | 1: use `ae_ofs`/`af_ofs`; 0: use the default offset |
| ae_ofs | input | log2(DEPTH) | Almost-empty offset in words |
| af_ofs | input | log2(DEPTH) | Almost-full offset in words |
| dout | output | DW | Registered read data |
| empty_n | output | 1 | Empty flag, active low, read domain |
| full_n | output | 1 | Full flag, active low, write domain |
| aempty | output | 1 | Almost-empty flag, read domain |
| afull | output | 1 | Almost-full flag, write domain |

## Verification
The assertions assume the following about the inputs:
- `rst_n` is held low across at least one edge of each clock, so the mode strap and the synchronisers start from known values.
- The offset inputs change only while both domains are idle.
- Enables and data are stable around the clock edge that samples them.

The bench keeps within these assumptions. It drives all write-side inputs on falling `wr_clk` edges and all read-side inputs on falling `rd_clk` edges. It changes offsets only after both domains have settled, and it holds reset for several write clocks. Random traffic comes from a fixed seed and is mixed with directed threshold sweeps, full and empty edge cases, and mode straps.

// File: rtl/twoclk_fifo9.sv
`timescale 1ns/1ps
module twoclk_fifo9 #(
  parameter int DW      = 9,
  parameter int DEPTH   = 16,
  parameter int DEF_OFS = 7
) (
  input  logic                     wr_clk,
  input  logic                     rd_clk,
  input  logic                     rst_n,
  input  logic                     wr_en1_n,
  input  logic                     wr_en2,
  input  logic [DW-1:0]            din,
  input  logic                     rd_en1_n,
  input  logic                     rd_en2_n,
  input  logic                     ofs_prog,
  input  logic [$clog2(DEPTH)-1:0] ae_ofs,
  input  logic [$clog2(DEPTH)-1:0] af_ofs,
  output logic [DW-1:0]            dout,
  output logic                     empty_n,
  output logic                     full_n,
  output logic                     aempty,
  output logic                     afull
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW:0] wptr, rptr, wgray, rgray;
  logic [AW:0] wg_s1, wg_s2, rg_s1, rg_s2;
  logic [AW:0] wnext, rnext, wsync_b, rsync_b, fill_r, fill_w;
  logic [AW-1:0] ae_thr, af_thr;
  logic two_we, wr_fire, rd_fire;

  function automatic logic [AW:0] gray2bin(input logic [AW:0] g);
    logic [AW:0] b;
    b[AW] = g[AW];
    for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  assign wnext   = wptr + 1'b1;
  assign rnext   = rptr + 1'b1;
  assign wsync_b = gray2bin(wg_s2);
  assign rsync_b = gray2bin(rg_s2);
  assign fill_r  = wsync_b - rptr;
  assign fill_w  = wptr - rsync_b;
  assign ae_thr  = ofs_prog ? ae_ofs : AW'(DEF_OFS);
  assign af_thr  = ofs_prog ? af_ofs : AW'(DEF_OFS);

  assign empty_n = (fill_r != '0);
  assign full_n  = (fill_w != FULL_CNT);
  assign aempty  = (fill_r <= {1'b0, ae_thr});
  assign afull   = (fill_w >= FULL_CNT - {1'b0, af_thr});

  assign wr_fire = rst_n && !wr_en1_n && (wr_en2 || !two_we) && full_n;
  assign rd_fire = !rd_en1_n && !rd_en2_n && empty_n;

  always_ff @(posedge wr_clk)
    if (!rst_n) two_we <= wr_en2;

  always_ff @(posedge wr_clk)
    if (wr_fire) mem[wptr[AW-1:0]] <= din;

  always_ff @(posedge wr_clk or negedge rst_n)
    if (!rst_n) begin
      wptr  <= '0;
      wgray <= '0;
      rg_s1 <= '0;
      rg_s2 <= '0;
    end else begin
      rg_s1 <= rgray;
      rg_s2 <= rg_s1;
      if (wr_fire) begin
        wptr  <= wnext;
        wgray <= wnext ^ (wnext >> 1);
      end
    end

  always_ff @(posedge rd_clk or negedge rst_n)
    if (!rst_n) begin
      rptr  <= '0;
      rgray <= '0;
      wg_s1 <= '0;
      wg_s2 <= '0;
      dout  <= '0;
    end else begin
      wg_s1 <= wgray;
      wg_s2 <= wg_s1;
      if (rd_fire) begin
        rptr  <= rnext;
        rgray <= rnext ^ (rnext >> 1);
        dout  <= mem[rptr[AW-1:0]];
      end
    end

  assert_no_overflow_R3: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !full_n |=> $stable(wptr));
  assert_no_underflow_R3: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !empty_n |=> ($stable(rptr) && $stable(dout)));
  assert_read_step_R2: assert property (@(posedge rd_clk) disable iff (!rst_n)
    rd_fire |=> (rptr == $past(rptr) + 1'b1));
  assert_fill_bound_R4: assert property (@(posedge wr_clk) disable iff (!rst_n)
    fill_w <= FULL_CNT);
  assert_read_fill_bound_R4: assert property (@(posedge rd_clk) disable iff (!rst_n)
    fill_r <= FULL_CNT);
  assert_full_implies_afull_R6: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !full_n |-> afull);
endmodule

// File: tb/twoclk_fifo9_test.sv
`timescale 1ns/1ps
module twoclk_fifo9_test;
  localparam int DW = 9, DEPTH = 16, AW = 4, DEF = 7;

  logic wr_clk = 0, rd_clk = 0, rst_n = 0;
  logic wr_en1_n = 1, wr_en2 = 1, rd_en1_n = 1, rd_en2_n = 1, ofs_prog = 0;
  logic [DW-1:0] din = '0;
  logic [AW-1:0] ae_ofs = '0, af_ofs = '0;
  logic [DW-1:0] dout;
  logic empty_n, full_n, aempty, afull;

  twoclk_fifo9 #(.DW(DW), .DEPTH(DEPTH), .DEF_OFS(DEF)) uut (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
    .wr_en1_n(wr_en1_n), .wr_en2(wr_en2), .din(din),
    .rd_en1_n(rd_en1_n), .rd_en2_n(rd_en2_n),
    .ofs_prog(ofs_prog), .ae_ofs(ae_ofs), .af_ofs(af_ofs),
    .dout(dout), .empty_n(empty_n), .full_n(full_n),
    .aempty(aempty), .afull(afull));

  always #2.5 wr_clk = ~wr_clk;
  always #3.7 rd_clk = ~rd_clk;

  int n_tests = 0, n_fail = 0, r5_bad = 0;
  logic [DW-1:0] q[$];
  logic [DW-1:0] last = '0;
  bit rpend = 0, mode_two = 1, started = 0, done = 0;
  realtime t_rd = -1.0, t_wr = -1.0;

  always @(posedge rd_clk) t_rd = $realtime;
  always @(posedge wr_clk) t_wr = $realtime;
  always @(empty_n or aempty) if (started && rst_n && $realtime != t_rd) r5_bad++;
  always @(full_n or afull)   if (started && rst_n && $realtime != t_wr) r5_bad++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit exp_ae(input int n);
    return ofs_prog ? (n <= int'(ae_ofs)) : (n <= DEF);
  endfunction
  function automatic bit exp_af(input int n);
    return ofs_prog ? (n >= DEPTH - int'(af_ofs)) : (n >= DEPTH - DEF);
  endfunction

  task automatic wr_cycle(input logic e1n, input logic e2, input logic [DW-1:0] d);
    @(negedge wr_clk);
    wr_en1_n = e1n; wr_en2 = e2; din = d;
    if (!e1n && (e2 || !mode_two) && full_n) q.push_back(d);
  endtask

  task automatic rd_cycle(input logic e1n, input logic e2n);
    logic [DW-1:0] exp;
    @(negedge rd_clk);
    if (rpend) begin
      if (q.size() == 0) check(0, "R4 read with nothing queued", 0, 1);
      else begin
        exp = q.pop_front();
        last = exp;
        check(dout == exp, "R2/R4 read data", dout, exp);
      end
    end else check(dout == last, "R3 output hold", dout, last);
    rd_en1_n = e1n; rd_en2_n = e2n;
    rpend = !e1n && !e2n && empty_n;
  endtask

  task automatic settle();
    @(negedge wr_clk); wr_en1_n = 1;
    repeat (4) @(negedge wr_clk);
    repeat (4) @(negedge rd_clk);
  endtask

  task automatic check_flags(input string req);
    int n = q.size();
    check(empty_n == (n != 0), {req, " empty_n"}, empty_n, n != 0);
    check(full_n == (n != DEPTH), {req, " full_n"}, full_n, n != DEPTH);
    check(aempty == exp_ae(n), {req, " aempty"}, aempty, exp_ae(n));
    check(afull == exp_af(n), {req, " afull"}, afull, exp_af(n));
  endtask

  task automatic drain();
    settle();
    repeat (DEPTH + 4) rd_cycle(0, 0);
    rd_cycle(1, 1);
    settle();
  endtask

  task automatic do_reset(input logic strap);
    started = 0;
    rst_n = 0;
    wr_en1_n = 0; wr_en2 = strap; rd_en1_n = 0; rd_en2_n = 0; din = 9'h1A5;
    repeat (4) @(negedge wr_clk);
    @(negedge rd_clk);
    check(dout == 0 && !empty_n && full_n && aempty && !afull, "R8 outputs in reset",
          {dout, empty_n, full_n, aempty, afull}, 10'b0000000000_0 | 10'b0110);
    @(negedge wr_clk);
    wr_en1_n = 1; rd_en1_n = 1; rd_en2_n = 1;
    rst_n = 1;
    mode_two = strap;
    q.delete(); last = '0; rpend = 0;
    started = 1;
  endtask

  initial begin
    #500000;
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset(1);
    settle();
    check_flags("R8 after reset with attempted access");
    check(dout == 0, "R8 dout zero", dout, 0);

    for (int i = 0; i < 3; i++) wr_cycle(0, 0, 9'(10 + i));
    for (int i = 0; i < 5; i++) wr_cycle(0, 1, 9'(20 + i));
    settle();
    check(q.size() == 5, "R1 model count", q.size(), 5);
    check_flags("R1 qualified writes only");
    rd_cycle(0, 1); rd_cycle(1, 0); rd_cycle(1, 1);
    check(q.size() == 5, "R2 single enable ignored", q.size(), 5);
    repeat (5) rd_cycle(0, 0);
    rd_cycle(1, 1);
    check(last == 9'd24, "R4 last word in order", last, 24);

    for (int i = 0; i < DEPTH + 4; i++) wr_cycle(0, 1, 9'(100 + i));
    settle();
    check(q.size() == DEPTH, "R3 overflow ignored", q.size(), DEPTH);
    check_flags("R6 full state");
    drain();
    check(last == 9'(100 + DEPTH - 1), "R3 last stored before full", last, 100 + DEPTH - 1);
    repeat (4) rd_cycle(0, 0);
    rd_cycle(1, 1);
    check_flags("R3 after underflow attempts");

    for (int n = 0; n <= DEPTH; n++) begin
      settle();
      check_flags("R6 default threshold sweep");
      if (n < DEPTH) wr_cycle(0, 1, 9'($urandom));
    end
    drain();

    ofs_prog = 1;
    ae_ofs = AW'(1 + $urandom % (DEPTH - 2));
    af_ofs = AW'(1 + $urandom % (DEPTH - 2));
    for (int n = 0; n <= DEPTH; n++) begin
      settle();
      check_flags("R7 programmed threshold sweep");
      if (n < DEPTH) wr_cycle(0, 1, 9'($urandom));
    end
    drain();
    ae_ofs = '0; af_ofs = AW'(DEPTH - 1);
    settle();
    check_flags("R7 extreme offsets");
    ofs_prog = 0;

    do_reset(0);
    for (int i = 0; i < 4; i++) wr_cycle(0, 0, 9'(300 + i));
    wr_cycle(1, 1, 9'h0);
    settle();
    check(q.size() == 4, "R9 programmable mode write count", q.size(), 4);
    check_flags("R9 programmable mode flags");
    drain();
    check(last == 9'd303, "R9 data", last, 303);

    do_reset(1);
    fork
      begin
        for (int i = 0; i < 3000; i++)
          wr_cycle(($urandom % 10) < 6 ? 1'b0 : 1'b1, ($urandom % 4) != 0, 9'($urandom));
        @(negedge wr_clk); wr_en1_n = 1;
      end
      begin
        for (int i = 0; i < 3000; i++)
          rd_cycle(($urandom % 10) < 3, ($urandom % 10) < 3);
        rd_cycle(1, 1);
      end
    join
    drain();
    check_flags("R4 after random traffic");

    for (int i = 0; i < 6; i++) wr_cycle(0, 1, 9'(i + 1));
    settle();
    rd_cycle(0, 0); rd_cycle(0, 0); rd_cycle(1, 1);
    do_reset(1);
    settle();
    check_flags("R8 mid-run reset");
    check(dout == 0, "R8 dout after mid-run reset", dout, 0);

    check(r5_bad == 0, "R5 flag change off own clock edge", r5_bad, 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule